// File: doc/BRIEF.md
# Programmable Pulse-Width Glitch Filter

This block cleans asynchronous digital inputs before they reach an edge-driven counter. Every channel has two inputs, a count input and a control input, and each input gets its own lane. In a lane the raw input first crosses into the system clock domain through two flip-flops. A new level then reaches the lane's output only after it has stayed the same for a programmable number of clock cycles. Any shorter excursion is thrown away. Each lane also gives one-cycle rising and falling strobes that follow the filtered level.

The minimum accepted width is a 10-bit cycle count and a single enable is shared by all lanes. Both are held in block-local registers. A write strobe loads them, and reset sets them to filtering on with a width of 16 cycles. When the enable is clear, each synchronised input drives its filtered level one cycle later with no qualification. Each lane runs a two-state machine:
- STABLE means the synchronised input equals the filtered level.
- QUAL means a differing input is being timed.

The transitions are:
- STABLE→STABLE: the input matches, the filter is disabled, or the new level is accepted at once.
- STABLE→QUAL: a difference is seen and the width has not yet been met.
- QUAL→QUAL: the difference persists and the count is still below the width.
- QUAL→STABLE: the width is met and the level is accepted, the input returns to the held level and the run is discarded, or the filter is disabled.

Top module: `pulse_glitch_filter`

## Requirements
- R1: After reset every filtered level and every strobe is 0, filtering is enabled and the minimum width is 16.
- R2: With the reset configuration, a synchronised excursion of 15 cycles is discarded and one of 16 cycles is accepted.
- R3: While filtering is enabled with minimum width N ≥ 2, a synchronised level that differs from the filtered level for fewer than N consecutive cycles leaves the filtered level unchanged.
- R4: While filtering is enabled with width N ≥ 1, a raw input change held steady appears on the filtered level exactly 2+N rising clock edges after it is applied: two synchroniser edges plus N qualifying edges.
- R5: While filtering is disabled, the filtered level equals the synchronised input one cycle later, so a raw change shows after 3 edges, and pulses of any width pass.
- R6: A minimum width of 0 or 1 behaves like bypass, with a latency of 3 edges.
- R7: The rise strobe is high for exactly the one cycle in which the filtered level has just gone 0→1, and the fall strobe for the cycle in which it has just gone 1→0. The two strobes are never high together.
- R8: When `cfg_wr` is high at a clock edge, `cfg_en` and `cfg_width` are captured at that edge and govern every lane from the next edge on. Without `cfg_wr` the configuration holds.
- R9: The lanes are independent. Activity on one channel's count or control input never changes another lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the filter configuration |
| cfg_en | input | 1 | Filter enable value to load (1 = filter, 0 = bypass) |
| cfg_width | input | 10 | Minimum accepted width in clock cycles, to load |
| raw_cnt | input | NUM_CH | Asynchronous count inputs, one per channel |
| raw_ctl | input | NUM_CH | Asynchronous control inputs, one per channel |
| cnt_lvl | output | NUM_CH | Filtered count levels |
| cnt_rise | output | NUM_CH | Rising strobes of the filtered count levels |
| cnt_fall | output | NUM_CH | Falling strobes of the filtered count levels |
| ctl_lvl | output | NUM_CH | Filtered control levels |
| ctl_rise | output | NUM_CH | Rising strobes of the filtered control levels |
| ctl_fall | output | NUM_CH | Falling strobes of the filtered control levels |

## Verification
A raw change reaches the filtered level 2+N edges after it is applied when filtering is enabled, and 3 edges after when it is bypassed or the width is 0 or 1. The matching strobe rises in the same cycle as the level. A configuration write takes effect at the edge after the one that captures it. The bench drives inputs on falling edges and runs a behavioural model that counts those same edges. It compares every output at each falling edge, so each result is checked in the cycle it is due. Directed latency measurements count falling edges from the stimulus until the level moves, and compare that count with 2+N or 3.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    // Per-lane qualification state
    typedef enum logic {
        ST_STABLE = 1'b0,   // synchronised input matches filtered level
        ST_QUAL   = 1'b1    // timing a differing input
    } lane_state_e;

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage synchroniser, one stage pair per bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/pgf_cfg.sv
module pgf_cfg #(
    parameter int THR_W     = 10,
    parameter int RESET_THR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             en_in,
    input  logic [THR_W-1:0] thr_in,
    output logic             en_q,
    output logic [THR_W-1:0] thr_q
);

    localparam logic [THR_W-1:0] THR_RST = THR_W'(RESET_THR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            thr_q <= THR_RST;
        end else if (wr) begin
            en_q  <= en_in;
            thr_q <= thr_in;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(en_q) && $stable(thr_q))); // R8

endmodule

// File: rtl/pgf_lane.sv
module pgf_lane
    import pgf_pkg::*;
#(
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic             s_in,
    output logic             level,
    output logic             rise,
    output logic             fall
);

    localparam int CW = THR_W + 1;

    lane_state_e      state_q, state_nxt;
    logic [THR_W-1:0] cnt_q, cnt_nxt;
    logic             level_q, level_nxt;
    logic             rise_q, fall_q;
    logic [CW-1:0]    cnt_inc;
    logic             differs;
    logic             met;

    assign differs = (s_in != level_q);
    assign cnt_inc = {1'b0, cnt_q} + CW'(1);
    assign met     = (cnt_inc >= {1'b0, thr});

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
            cnt_q   <= '0;
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            level_q <= level_nxt;
            rise_q  <= level_nxt & ~level_q;
            fall_q  <= ~level_nxt & level_q;
        end
    end

    // Transition process
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_STABLE: begin
                if (en && differs && !met) state_nxt = ST_QUAL;
                else                       state_nxt = ST_STABLE;
            end
            ST_QUAL: begin
                if (!en || !differs || met) state_nxt = ST_STABLE;
                else                        state_nxt = ST_QUAL;
            end
            default: state_nxt = ST_STABLE;
        endcase
    end

    // Output / datapath process
    always_comb begin
        level_nxt = level_q;
        cnt_nxt   = '0;
        if (!en) begin
            level_nxt = s_in;
        end else if (differs && met) begin
            level_nxt = s_in;
        end
        if (state_nxt == ST_QUAL) cnt_nxt = cnt_inc[THR_W-1:0];
    end

    assign level = level_q;
    assign rise  = rise_q;
    assign fall  = fall_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q)); // R7
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (level_q && !$past(level_q))); // R7
    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!level_q && $past(level_q))); // R7
    AST_LEVEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> (level_q == $past(s_in))); // R4
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (level_q == $past(s_in))); // R5
    AST_QUAL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(thr) && state_q == ST_QUAL) |-> ({1'b0, cnt_q} < {1'b0, thr})); // R3

endmodule

// File: rtl/pulse_glitch_filter.sv
module pulse_glitch_filter #(
    parameter int NUM_CH    = 2,
    parameter int THR_W     = 10,
    parameter int RESET_THR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [THR_W-1:0]  cfg_width,
    input  logic [NUM_CH-1:0] raw_cnt,
    input  logic [NUM_CH-1:0] raw_ctl,
    output logic [NUM_CH-1:0] cnt_lvl,
    output logic [NUM_CH-1:0] cnt_rise,
    output logic [NUM_CH-1:0] cnt_fall,
    output logic [NUM_CH-1:0] ctl_lvl,
    output logic [NUM_CH-1:0] ctl_rise,
    output logic [NUM_CH-1:0] ctl_fall
);

    // Lanes 0..NUM_CH-1 carry count inputs, NUM_CH..2*NUM_CH-1 control inputs
    localparam int NLANE = 2 * NUM_CH;

    logic             en_q;
    logic [THR_W-1:0] thr_q;
    logic [NLANE-1:0] raw_all, sync_all;
    logic [NLANE-1:0] lvl_all, rise_all, fall_all;

    assign raw_all = {raw_ctl, raw_cnt};

    pgf_cfg #(.THR_W(THR_W), .RESET_THR(RESET_THR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .en_in(cfg_en),
        .thr_in(cfg_width), .en_q(en_q), .thr_q(thr_q)
    );

    pgf_sync #(.WIDTH(NLANE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_all), .q_sync(sync_all)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        pgf_lane #(.THR_W(THR_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(en_q), .thr(thr_q),
            .s_in(sync_all[g]), .level(lvl_all[g]),
            .rise(rise_all[g]), .fall(fall_all[g])
        );
    end

    assign cnt_lvl  = lvl_all[NUM_CH-1:0];
    assign cnt_rise = rise_all[NUM_CH-1:0];
    assign cnt_fall = fall_all[NUM_CH-1:0];
    assign ctl_lvl  = lvl_all[NLANE-1:NUM_CH];
    assign ctl_rise = rise_all[NLANE-1:NUM_CH];
    assign ctl_fall = fall_all[NLANE-1:NUM_CH];

endmodule

// File: tb/sim_pulse_glitch_filter.sv
`timescale 1ns/1ps
module sim_pulse_glitch_filter;

    localparam int NC = 2;
    localparam int TW = 10;
    localparam int NL = 2 * NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_en = 1'b1;
    logic [TW-1:0] cfg_width = '0;
    logic [NC-1:0] raw_cnt = '0, raw_ctl = '0;
    logic [NC-1:0] cnt_lvl, cnt_rise, cnt_fall, ctl_lvl, ctl_rise, ctl_fall;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    pulse_glitch_filter #(.NUM_CH(NC), .THR_W(TW), .RESET_THR(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_width(cfg_width), .raw_cnt(raw_cnt), .raw_ctl(raw_ctl),
        .cnt_lvl(cnt_lvl), .cnt_rise(cnt_rise), .cnt_fall(cnt_fall),
        .ctl_lvl(ctl_lvl), .ctl_rise(ctl_rise), .ctl_fall(ctl_fall)
    );

    // ---------------- behavioural reference model ----------------
    int m_s1[NL], m_s2[NL], m_lvl[NL], m_run[NL], m_rise[NL], m_fall[NL];
    int m_en, m_thr;

    function automatic int raw_of(int l);
        return (l < NC) ? int'(raw_cnt[l]) : int'(raw_ctl[l-NC]);
    endfunction
    function automatic int lvl_of(int l);
        return (l < NC) ? int'(cnt_lvl[l]) : int'(ctl_lvl[l-NC]);
    endfunction
    function automatic int rise_of(int l);
        return (l < NC) ? int'(cnt_rise[l]) : int'(ctl_rise[l-NC]);
    endfunction
    function automatic int fall_of(int l);
        return (l < NC) ? int'(cnt_fall[l]) : int'(ctl_fall[l-NC]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < NL; l++) begin
                m_s1[l] = 0; m_s2[l] = 0; m_lvl[l] = 0;
                m_run[l] = 0; m_rise[l] = 0; m_fall[l] = 0;
            end
            m_en = 1; m_thr = 16;
        end else begin
            for (int l = 0; l < NL; l++) begin
                int nl, nr;
                nl = m_lvl[l]; nr = 0;
                if (m_en == 0) nl = m_s2[l];
                else if (m_s2[l] != m_lvl[l]) begin
                    nr = m_run[l] + 1;
                    if (nr >= m_thr) begin nl = m_s2[l]; nr = 0; end
                end
                m_rise[l] = (nl == 1 && m_lvl[l] == 0) ? 1 : 0;
                m_fall[l] = (nl == 0 && m_lvl[l] == 1) ? 1 : 0;
                m_lvl[l] = nl; m_run[l] = nr;
                m_s2[l] = m_s1[l]; m_s1[l] = raw_of(l);
            end
            if (cfg_wr) begin m_en = int'(cfg_en); m_thr = int'(cfg_width); end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < NL; l++) begin
                checks++;
                if (lvl_of(l) != m_lvl[l]) begin
                    fails++;
                    $display("FAIL %s lane %0d level act=%0d exp=%0d t=%0t",
                             m_en ? "R4" : "R5", l, lvl_of(l), m_lvl[l], $time);
                end
                checks++;
                if (rise_of(l) != m_rise[l] || fall_of(l) != m_fall[l]) begin
                    fails++;
                    $display("FAIL R7 lane %0d rise/fall act=%0d%0d exp=%0d%0d t=%0t",
                             l, rise_of(l), fall_of(l), m_rise[l], m_fall[l], $time);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic set_raw(input int l, input bit v);
        if (l < NC) raw_cnt[l] = v; else raw_ctl[l-NC] = v;
    endtask

    task automatic write_cfg(input bit en, input int w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_width = TW'(w);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a raw level and count falling edges until the filtered level follows
    task automatic measure(input int l, input bit v, output int n);
        @(negedge clk);
        set_raw(l, v);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (lvl_of(l) != int'(v) && n < 2000);
    endtask

    task automatic pulse(input int l, input bit v, input int w);
        @(negedge clk);
        set_raw(l, v);
        repeat (w) @(negedge clk);
        set_raw(l, !v);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog expired act=%0d exp=0", cycles);
            finish_run();
        end
    end

    // ---------------- directed stimulus ----------------
    initial begin
        int n;
        int rises;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 levels zero", int'({cnt_lvl, ctl_lvl}), 0);
        check("R1 strobes zero", int'({cnt_rise, cnt_fall, ctl_rise, ctl_fall}), 0);
        rst_n = 1'b1;
        idle(4);

        // R2/R3: default width 16, 15-cycle pulse discarded
        pulse(0, 1'b1, 15);
        idle(30);
        check("R2 R3 15-cycle pulse discarded", int'(cnt_lvl[0]), 0);
        // R2/R4: 16 accepted, latency 2+16
        measure(0, 1'b1, n);
        check("R2 R4 default rise latency", n, 18);
        measure(0, 1'b0, n);
        check("R4 default fall latency", n, 18);

        // R8: new width 5 applies from next edge
        write_cfg(1'b1, 5);
        pulse(1, 1'b1, 4);
        idle(12);
        check("R3 R8 4-cycle pulse at width 5", int'(cnt_lvl[1]), 0);
        measure(1, 1'b1, n);
        check("R4 R8 latency at width 5", n, 7);

        // R7: strobes around a full pulse
        rises = 0;
        @(negedge clk); set_raw(2, 1'b1);
        repeat (12) begin @(negedge clk); rises += int'(ctl_rise[0]); end
        check("R7 single rise strobe", rises, 1);
        check("R7 level high after rise", int'(ctl_lvl[0]), 1);

        // R9: only lane 2 was driven; lane 3 and lane 0 untouched
        check("R9 other control lane idle", int'(ctl_lvl[1]), 0);
        check("R9 count lane 0 idle", int'(cnt_lvl[0]), 0);

        // R5: bypass passes a 1-cycle pulse, latency 3
        write_cfg(1'b0, 5);
        measure(3, 1'b1, n);
        check("R5 bypass latency", n, 3);
        pulse(0, 1'b1, 1);
        @(negedge clk); @(negedge clk);
        check("R5 narrow pulse passes", int'(cnt_lvl[0]), 1);
        idle(4);

        // R6: width 0 and 1 behave like bypass
        write_cfg(1'b1, 0);
        measure(3, 1'b0, n);
        check("R6 width 0 latency", n, 3);
        write_cfg(1'b1, 1);
        measure(3, 1'b1, n);
        check("R6 width 1 latency", n, 3);

        // Noise with width 3, then enable toggles; model compares every cycle
        write_cfg(1'b1, 3);
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) raw_cnt = lfsr[2:1];
            if (lfsr[3]) raw_ctl = lfsr[5:4];
            if (i == 1500) begin cfg_wr = 1'b1; cfg_en = 1'b0; end
            else if (i == 2200) begin cfg_wr = 1'b1; cfg_en = 1'b1; cfg_width = 10'd7; end
            else cfg_wr = 1'b0;
        end
        cfg_wr = 1'b0;
        idle(20);
        finish_run();
    end

endmodule